// File: doc/BRIEF.md
# Test Access Port Slave with an 8-bit User Register

This block is the serial test port of one device. A test controller drives a test clock, a mode-select line and a serial data input. The block follows the standard sixteen-state test port controller on each rising edge of the test clock. It returns one serial data bit, and an enable that is high only while a register is being shifted. An active-low reset input returns the port to its reset state at any time, independent of the clock.

The port holds a 3-bit instruction register and two data registers: a 1-bit bypass stage and an 8-bit user register. The instruction decides which of the two data registers sits between the serial input and the serial output. The user register has two parallel buses. One is sampled when a data scan begins. The other is written when the scan ends. All scans move the least-significant bit first, so one pass reads the captured value and writes the new one.

Top module: `jtag_tap_user`

## Requirements
- R1: With the mode-select line held at 1 for five rising clock edges, the controller reaches its reset state from any state. In that state the instruction becomes 3'b110 (bypass).
- R2: From the reset state, the mode-select sequence 0,1,1,0,0 reaches the instruction-shift state. On the following falling edge the output enable is 1.
- R3: The instruction register is 3 bits wide. Capture loads 3'b001 into its shift stage, which therefore shows 1,0,0 on the serial output. It shifts LSB first from the serial input toward the serial output, and its value takes effect in the instruction-update state.
- R4: Instruction 3'b010 places the 8-bit user register in the data path. Bit k shifted in appears on the serial output 8 shifts later.
- R5: Instruction 3'b110, and every code other than 3'b010, places the 1-bit bypass stage in the data path. It captures 0 and delays data by one shift.
- R6: On a data capture with the user register selected, the shift stage loads `user_cap_i`. Its bits appear on the serial output LSB first while new bits are shifted in.
- R7: `user_upd_o` takes the user shift stage value only in the data-update state with the user register selected. It holds at all other times, including during a shift and during bypass scans.
- R8: The serial output and its enable change only on the falling clock edge. The enable is 1 only while the controller is in the instruction-shift or data-shift state.
- R9: `trst_n` low at once forces the reset state, clears `tdo`, `tdo_oe` and `user_upd_o`, and sets the instruction to bypass.
- R10: From instruction-shift, the sequence 1,1,1,0,0 reaches data-shift. From data-shift, the sequence 1,1,0 passes through the data-update state and returns to idle with the enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | High while a register is shifted |
| user_cap_i | input | 8 | Value captured into the user register |
| user_upd_o | output | 8 | Value written by the last user update |

## Verification
On every cycle, the assertions check the following:
- the five-high reset rule;
- the loads into the instruction shift stage and the user shift stage;
- that the instruction becomes bypass in the reset state;
- that the update bus changes only in a user update;
- that the output enable matches the shift states;
- that reset keeps the outputs quiet.

Only the bench's scenarios show the end-to-end behaviour: the exact mode-select paths, the bit order and path length seen at the serial output, the routing of unused codes to bypass, and recovery into bypass after a reset in the middle of a scan.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_t;

  // Controller transition for one rising edge, given the mode-select bit.
  function automatic tap_state_t tap_next(input tap_state_t cur, input logic m);
    tap_state_t n;
    case (cur)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      default:   n = m ? ST_SEL_DR : ST_IDLE;
    endcase
    return n;
  endfunction

  // True in the two states that drive the serial output.
  function automatic logic tap_is_shift(input tap_state_t s);
    return (s == ST_SH_DR) || (s == ST_SH_IR);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir #(
  parameter int              IR_W      = 3,
  parameter logic [IR_W-1:0] CODE_BYP  = 3'b110,
  parameter logic [IR_W-1:0] CODE_CAPT = 3'b001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            in_reset,
  input  logic            cap,
  input  logic            shift,
  input  logic            upd,
  output logic [IR_W-1:0] ir_sh,
  output logic [IR_W-1:0] ir_q
);

  // Shift stage: LSB leaves toward the serial output first.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    ir_sh <= CODE_CAPT;
    else if (cap)   ir_sh <= CODE_CAPT;
    else if (shift) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  // Active instruction.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ir_q <= CODE_BYP;
    else if (in_reset) ir_q <= CODE_BYP;
    else if (upd)      ir_q <= ir_sh;
  end

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr #(
  parameter int DR_W = 8
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            cap,
  input  logic            shift,
  input  logic            upd,
  input  logic            sel_user,
  input  logic [DR_W-1:0] cap_data,
  output logic [DR_W-1:0] usr_sh,
  output logic            byp_q,
  output logic [DR_W-1:0] upd_data
);

  logic [DR_W-1:0] usr_shifted;

  generate
    if (DR_W == 1) begin : g_one
      assign usr_shifted = tdi;
    end else begin : g_many
      assign usr_shifted = {tdi, usr_sh[DR_W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 usr_sh <= '0;
    else if (cap && sel_user)    usr_sh <= cap_data;
    else if (shift && sel_user)  usr_sh <= usr_shifted;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 byp_q <= 1'b0;
    else if (cap && !sel_user)   byp_q <= 1'b0;
    else if (shift && !sel_user) byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              upd_data <= '0;
    else if (upd && sel_user) upd_data <= usr_sh;
  end

endmodule

// File: rtl/jtag_tap_user.sv
`timescale 1ns/1ps
module jtag_tap_user
  import tap_pkg::*;
#(
  parameter int              IR_W      = 3,
  parameter int              DR_W      = 8,
  parameter logic [IR_W-1:0] CODE_BYP  = 3'b110,
  parameter logic [IR_W-1:0] CODE_USER = 3'b010,
  parameter logic [IR_W-1:0] CODE_CAPT = 3'b001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [DR_W-1:0] user_cap_i,
  output logic [DR_W-1:0] user_upd_o
);

  tap_state_t      st;
  logic [IR_W-1:0] ir_q, ir_sh;
  logic [DR_W-1:0] usr_sh;
  logic            byp_q;

  // Named controller events.
  logic ev_reset, ev_cap_ir, ev_sh_ir, ev_upd_ir;
  logic ev_cap_dr, ev_sh_dr, ev_upd_dr, sel_user, out_bit;

  assign ev_reset  = (st == ST_RESET);
  assign ev_cap_ir = (st == ST_CAP_IR);
  assign ev_sh_ir  = (st == ST_SH_IR);
  assign ev_upd_ir = (st == ST_UPD_IR);
  assign ev_cap_dr = (st == ST_CAP_DR);
  assign ev_sh_dr  = (st == ST_SH_DR);
  assign ev_upd_dr = (st == ST_UPD_DR);
  assign sel_user  = (ir_q == CODE_USER);

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(st)
  );

  tap_ir #(.IR_W(IR_W), .CODE_BYP(CODE_BYP), .CODE_CAPT(CODE_CAPT)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(ev_reset),
    .cap(ev_cap_ir), .shift(ev_sh_ir), .upd(ev_upd_ir),
    .ir_sh(ir_sh), .ir_q(ir_q)
  );

  tap_dr #(.DR_W(DR_W)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .cap(ev_cap_dr), .shift(ev_sh_dr), .upd(ev_upd_dr), .sel_user(sel_user),
    .cap_data(user_cap_i), .usr_sh(usr_sh), .byp_q(byp_q), .upd_data(user_upd_o)
  );

  assign out_bit = ev_sh_ir ? ir_sh[0] : (sel_user ? usr_sh[0] : byp_q);

  // Output stage on the falling edge.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= tap_is_shift(st);
      if (tap_is_shift(st)) tdo <= out_bit;
    end
  end

endmodule

// File: rtl/tap_checker.sv
`timescale 1ns/1ps
module tap_checker
  import tap_pkg::*;
#(
  parameter int              IR_W      = 3,
  parameter int              DR_W      = 8,
  parameter logic [IR_W-1:0] CODE_BYP  = 3'b110,
  parameter logic [IR_W-1:0] CODE_CAPT = 3'b001
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_t      st,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sh,
  input logic [DR_W-1:0] usr_sh,
  input logic [DR_W-1:0] user_cap_i,
  input logic [DR_W-1:0] user_upd_o,
  input logic            tdo_oe,
  input logic            ev_cap_ir,
  input logic            ev_cap_dr,
  input logic            ev_upd_dr,
  input logic            sel_user
);

  // Run of consecutive high mode-select samples, saturating at five.
  logic [2:0] hi_run;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          hi_run <= 3'd0;
    else if (!tms)        hi_run <= 3'd0;
    else if (hi_run != 5) hi_run <= hi_run + 3'd1;
  end

  assert_five_high_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_run == 3'd5) |-> (st == ST_RESET));

  assert_reset_bypass_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_RESET) |=> (ir_q == CODE_BYP));

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
    ev_cap_ir |=> (ir_sh == CODE_CAPT));

  assert_dr_capture_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (ev_cap_dr && sel_user) |=> (usr_sh == $past(user_cap_i)));

  assert_update_load_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (ev_upd_dr && sel_user) |=> (user_upd_o == $past(usr_sh)));

  assert_update_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
    !(ev_upd_dr && sel_user) |=> $stable(user_upd_o));

  assert_oe_in_shift_R8: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == tap_is_shift(st));

  assert_reset_quiet_R9: assert property (@(posedge tck)
    !trst_n |-> (!tdo_oe && (user_upd_o == '0) && (st == ST_RESET)));

endmodule

bind jtag_tap_user tap_checker #(
  .IR_W(IR_W), .DR_W(DR_W), .CODE_BYP(CODE_BYP), .CODE_CAPT(CODE_CAPT)
) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_q(ir_q), .ir_sh(ir_sh),
  .usr_sh(usr_sh), .user_cap_i(user_cap_i), .user_upd_o(user_upd_o),
  .tdo_oe(tdo_oe), .ev_cap_ir(ev_cap_ir), .ev_cap_dr(ev_cap_dr),
  .ev_upd_dr(ev_upd_dr), .sel_user(sel_user)
);

// File: tb/test_jtag_tap_user.sv
`timescale 1ns/1ps
module test_jtag_tap_user;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo, tdo_oe;
  logic [7:0] user_cap_i = 8'hA3;
  logic [7:0] user_upd_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic  exp_bits[$];
  string exp_tags[$];

  always #2.5 tck = ~tck;

  jtag_tap_user i_jtag_tap_user (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .user_cap_i(user_cap_i), .user_upd_o(user_upd_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one test clock with the given inputs. It optionally queues
  // the bit expected on tdo during this clock.
  task automatic step(input logic t, input logic d, input bit push, input logic e, input string tag);
    logic seen;
    @(negedge tck); #1;
    if (push) begin
      exp_bits.push_back(e);
      exp_tags.push_back(tag);
    end
    tms = t;
    tdi = d;
    seen = tdo;
    @(posedge tck); #1;
    if (push) chk(tdo === seen, "R8 tdo moved at rising edge", {15'd0, tdo}, {15'd0, seen});
  endtask

  task automatic walk(input string s);
    for (int i = 0; i < s.len(); i++) step(s[i] == 8'h31, 1'b0, 1'b0, 1'b0, "");
  endtask

  // Scan len bits through a register of length len_reg holding cap.
  // The last bit leaves the shift state.
  task automatic scan(input int len, input int len_reg, input logic [15:0] cap,
                      input logic [15:0] din, input string tag0, input string tag,
                      output logic [15:0] fin);
    logic [15:0] m;
    m = cap & ((16'd1 << len_reg) - 16'd1);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i], 1'b1, m[0], (i == 0) ? tag0 : tag);
      m = m >> 1;
      m[len_reg-1] = din[i];
    end
    fin = m;
  endtask

  // Monitor: pops expected serial bits and compares them at the falling edge.
  initial begin
    logic  e;
    string t;
    forever begin
      @(negedge tck); #2;
      if (exp_bits.size() > 0) begin
        e = exp_bits.pop_front();
        t = exp_tags.pop_front();
        chk((tdo_oe === 1'b1) && (tdo === e), t, {14'd0, tdo_oe, tdo}, {14'd0, 1'b1, e});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] f;
    repeat (3) @(posedge tck);
    #1;
    chk(tdo_oe === 1'b0 && tdo === 1'b0, "R9 reset outputs", {14'd0, tdo_oe, tdo}, 16'd0);
    chk(user_upd_o === 8'h00, "R9 reset update bus", {8'd0, user_upd_o}, 16'd0);
    @(negedge tck); #1 trst_n = 1'b1;

    // R1 R5: reset state selects bypass; 1-bit delay, captures 0
    walk("11111");
    walk("0100");
    scan(4, 1, 16'h0, 16'h000D, "R5", "R5", f);
    chk(user_upd_o === 8'h00, "R7 hold during bypass", {8'd0, user_upd_o}, 16'd0);
    walk("10");
    chk(tdo_oe === 1'b0, "R8 enable low in idle", {15'd0, tdo_oe}, 16'd0);
    chk(user_upd_o === 8'h00, "R7 bypass update no effect", {8'd0, user_upd_o}, 16'd0);

    // R2: 0,1,1,0,0 from reset reaches instruction shift; R3 capture 001
    walk("11111");
    walk("01100");
    scan(3, 3, 16'h1, 16'h2, "R2", "R3", f);
    chk(f[2:0] === 3'b010, "R3 shifted code", f, 16'h2);
    // R10: 1 (within scan), then 1,1,0,0 reaches data shift
    walk("1100");
    scan(8, 8, 16'hA3, 16'hF5, "R10", "R6", f);
    chk(user_upd_o === 8'h00, "R7 hold during shift", {8'd0, user_upd_o}, 16'd0);
    walk("10");
    chk(tdo_oe === 1'b0, "R10 back in idle", {15'd0, tdo_oe}, 16'd0);
    chk(user_upd_o === f[7:0], "R7 update loads F5", {8'd0, user_upd_o}, f);

    // R4: 8-bit path length; excess bits come out after 8 shifts
    user_cap_i = 8'h5A;
    walk("100");
    scan(12, 8, 16'h5A, 16'h0B6D, "R4", "R4", f);
    walk("10");
    chk(user_upd_o === f[7:0], "R4 last eight bits updated", {8'd0, user_upd_o}, f);

    // R5: unused code 111 selects bypass
    walk("1100");
    scan(3, 3, 16'h1, 16'h7, "R3", "R3", f);
    walk("1100");
    scan(3, 1, 16'h0, 16'h5, "R5", "R5", f);
    walk("10");
    chk(user_upd_o === 8'hB6, "R7 unused code leaves bus", {8'd0, user_upd_o}, 16'h00B6);

    // R5: code 110 selects bypass
    walk("1100");
    scan(3, 3, 16'h1, 16'h6, "R3", "R3", f);
    walk("1100");
    scan(3, 1, 16'h0, 16'h3, "R5", "R5", f);
    walk("10");

    // R1: from inside the data path of the user register
    walk("1100");
    scan(3, 3, 16'h1, 16'h2, "R3", "R3", f);
    walk("11000");
    walk("10");
    walk("11111");
    walk("0100");
    scan(3, 1, 16'h0, 16'h6, "R1", "R1", f);
    walk("10");

    // R9: asynchronous reset in the middle of a user scan
    walk("1100");
    scan(3, 3, 16'h1, 16'h2, "R3", "R3", f);
    walk("11000");
    @(negedge tck); #1 trst_n = 1'b0;
    tms = 1'b1;
    #1;
    chk(tdo_oe === 1'b0, "R9 enable cleared", {15'd0, tdo_oe}, 16'd0);
    chk(user_upd_o === 8'h00, "R9 update bus cleared", {8'd0, user_upd_o}, 16'd0);
    @(negedge tck); #1 trst_n = 1'b1;
    walk("0100");
    scan(3, 1, 16'h0, 16'h5, "R9", "R9", f);
    walk("10");

    repeat (3) @(posedge tck);
    chk(exp_bits.size() == 0, "R8 all expected bits seen", 16'(exp_bits.size()), 16'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule